// File: doc/BRIEF.md
# Programmable Pin Wakeup Detector

This block is a single wakeup-detection channel clocked by the always-on clock. A select field picks one of a parameterized set of input pins. The chosen pin passes through a two-flop synchronizer and then an optional debounce filter. A pattern matcher watches the filtered level for a programmed event: a rising edge, a falling edge, any edge, or a high or low pulse whose width reaches a programmed threshold. Pulse width is measured by a saturating 8-bit counter.

When the programmed event occurs, the block sets a sticky cause flag and raises a wakeup request that follows the flag. The flag stays set until a one-cycle clear strobe removes it. A power controller consumes the request. Software is expected to disable the channel before it changes the mode, because the width counter is intentionally not cleared by a mode change while the channel is enabled.

Top module: `pin_wake_detector`

## Requirements
- R1: `mode_i` encodes the event: 0 rising edge, 1 falling edge, 2 any edge, 3 high pulse, 4 low pulse. Codes 5, 6 and 7 never produce a detection.
- R2: With the filter off, a pin change first sampled at clock edge k makes `cause_o` read 1 after edge k+2 and not before.
- R3: `pin_sel_i` picks the pin at that index of `pins_i`. Activity on any other pin produces no detection.
- R4: In modes 3 and 4, the channel detects when the filtered level leaves the active level (high for mode 3, low for mode 4) after W cycles at that level, exactly when W >= `thresh_i`.
- R5: The width counter saturates at 255. A pulse longer than 255 cycles is still detected against a threshold of 255, and a 254-cycle pulse is not.
- R6: With `filt_en_i` set, the filtered level follows the raw pin only after the pin has held its new value for 2 cycles. A 1-cycle glitch is dropped, and edge latency grows by 2 cycles over R2.
- R7: `cause_o` stays 1 until `cause_clr_i` is 1 at a clock edge. If a detection and a clear coincide, the detection wins.
- R8: `wake_req_o` equals `cause_o` at all times.
- R9: With `det_en_i` low, nothing is detected and the width counter is held at 0. Enabling the channel while the pin already sits at a level produces no edge event.
- R10: A mode change while the channel is enabled keeps the width count. The counter accrues while the level is high in modes 0 to 3 and while it is low in mode 4, so time at that level spent before the change counts toward the pulse width.
- R11: After synchronous reset, `cause_o` and `wake_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Candidate wakeup pins |
| pin_sel_i | input | clog2(NUM_PINS) | Index of the watched pin |
| det_en_i | input | 1 | Channel enable |
| mode_i | input | 3 | Event code (see R1) |
| filt_en_i | input | 1 | Debounce filter enable |
| thresh_i | input | CNT_W | Minimum pulse width in cycles |
| cause_clr_i | input | 1 | Clear strobe for the cause flag |
| cause_o | output | 1 | Sticky cause flag |
| wake_req_o | output | 1 | Wakeup request |

## Verification
The hardest situation to reach from the ports is a width count that survives a mode change. It needs the channel enabled in an edge mode while the pin is held high. The bench then clears the edge-caused flag, switches to high-pulse mode mid-level and releases the pin. It checks that the earlier high time met the threshold. A companion sequence disables and re-enables the channel around the same mode switch and expects no detection. The coincidence of a clear strobe with a detection is reached by timing the strobe to the exact cycle the edge reaches the matcher.

// File: rtl/wkdet_pkg.sv
package wkdet_pkg;

    typedef enum logic [2:0] {
        EV_RISE   = 3'd0,
        EV_FALL   = 3'd1,
        EV_ANY    = 3'd2,
        EV_HPULSE = 3'd3,
        EV_LPULSE = 3'd4,
        EV_RSV5   = 3'd5,
        EV_RSV6   = 3'd6,
        EV_RSV7   = 3'd7
    } wk_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } lvl_pair_t;

    function automatic logic is_pulse_mode(wk_mode_e m);
        return (m == EV_HPULSE) || (m == EV_LPULSE);
    endfunction

    // level at which the width counter accrues
    function automatic logic count_polarity(wk_mode_e m);
        return (m == EV_LPULSE) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/wkdet_pin_sync.sv
module wkdet_pin_sync #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                lvl_o
);
    logic                   picked;
    logic [SYNC_STAGES-1:0] chain_q;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_i == SEL_W'(i)) picked = pins_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= picked;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign lvl_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/wkdet_debounce.sv
module wkdet_debounce #(
    parameter int FILT_LEN = 2,
    localparam int FCNT_W  = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic raw_i,
    output logic lvl_o
);
    logic              held_q;
    logic [FCNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            run_q  <= '0;
        end else if (!en_i) begin
            held_q <= raw_i;
            run_q  <= '0;
        end else if (raw_i == held_q) begin
            run_q  <= '0;
        end else if (run_q == FCNT_W'(FILT_LEN - 1)) begin
            held_q <= raw_i;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign lvl_o = en_i ? held_q : raw_i;
endmodule

// File: rtl/wkdet_matcher.sv
module wkdet_matcher
    import wkdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             lvl_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wk_mode_e         mode;
    lvl_pair_t        lv;
    logic             prev_q;
    logic [CNT_W-1:0] width_q;
    logic             pol, cur_act, prev_act;
    logic             rise, fall, edge_hit, pulse_hit;

    assign mode     = wk_mode_e'(mode_i);
    assign lv       = '{cur: lvl_i, prev: prev_q};
    assign pol      = count_polarity(mode);
    assign cur_act  = (lv.cur == pol);
    assign prev_act = (lv.prev == pol);
    assign rise     = lv.cur & ~lv.prev;
    assign fall     = ~lv.cur & lv.prev;

    always_comb begin
        unique case (mode)
            EV_RISE: edge_hit = rise;
            EV_FALL: edge_hit = fall;
            EV_ANY:  edge_hit = rise | fall;
            default: edge_hit = 1'b0;
        endcase
    end

    assign pulse_hit = is_pulse_mode(mode) && prev_act && !cur_act
                       && (width_q >= thresh_i);
    assign hit_o     = en_i && (edge_hit || pulse_hit);
    assign width_o   = width_q;

    // history always tracks the level, so enabling never sees a stale edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i)        width_q <= '0;
        else if (!cur_act)       width_q <= '0;
        else if (width_q != CNT_MAX) width_q <= width_q + 1'b1;
    end
endmodule

// File: rtl/pin_wake_detector.sv
module pin_wake_detector
    import wkdet_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int CNT_W       = 8,
    parameter int FILT_LEN    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    pin_sel_i,
    input  logic                det_en_i,
    input  logic [2:0]          mode_i,
    input  logic                filt_en_i,
    input  logic [CNT_W-1:0]    thresh_i,
    input  logic                cause_clr_i,
    output logic                cause_o,
    output logic                wake_req_o
);
    logic             sync_lvl;
    logic             filt_lvl;
    logic             hit;
    logic [CNT_W-1:0] width_cnt;
    logic             cause_q;

    wkdet_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pins_i(pins_i),
        .sel_i (pin_sel_i),
        .lvl_o (sync_lvl)
    );

    wkdet_debounce #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .en_i (filt_en_i),
        .raw_i(sync_lvl),
        .lvl_o(filt_lvl)
    );

    wkdet_matcher #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .en_i    (det_en_i),
        .mode_i  (mode_i),
        .thresh_i(thresh_i),
        .lvl_i   (filt_lvl),
        .hit_o   (hit),
        .width_o (width_cnt)
    );

    // a new detection takes precedence over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)              cause_q <= 1'b0;
        else if (hit)         cause_q <= 1'b1;
        else if (cause_clr_i) cause_q <= 1'b0;
    end

    assign cause_o    = cause_q;
    assign wake_req_o = cause_q;
endmodule

// File: rtl/pin_wake_detector_chk.sv
module pin_wake_detector_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             det_en_i,
    input logic             filt_en_i,
    input logic             cause_clr_i,
    input logic             cause_o,
    input logic             wake_req_o,
    input logic             sync_lvl,
    input logic             filt_lvl,
    input logic [CNT_W-1:0] width_cnt
);
    // R7
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_o && !cause_clr_i) |=> cause_o);

    // R7
    cause_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cause_o) |-> $past(cause_clr_i));

    // R9
    rise_when_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_o) |-> $past(det_en_i));

    // R9
    width_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !det_en_i |=> (width_cnt == '0));

    // R5
    width_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (width_cnt != '0) |=> (width_cnt == '0) || (width_cnt >= $past(width_cnt)));

    // R6
    filt_move_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_en_i && $past(filt_en_i) && !$stable(filt_lvl))
            |-> $past(sync_lvl != filt_lvl));

    // R8
    wake_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cause_o) |-> !$stable(wake_req_o));
endmodule

bind pin_wake_detector pin_wake_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .det_en_i   (det_en_i),
    .filt_en_i  (filt_en_i),
    .cause_clr_i(cause_clr_i),
    .cause_o    (cause_o),
    .wake_req_o (wake_req_o),
    .sync_lvl   (sync_lvl),
    .filt_lvl   (filt_lvl),
    .width_cnt  (width_cnt)
);

// File: tb/pin_wake_detector_test.sv
module pin_wake_detector_test;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins_i = '0;
    logic [2:0]    pin_sel_i = '0;
    logic          det_en_i = 1'b0;
    logic [2:0]    mode_i = '0;
    logic          filt_en_i = 1'b0;
    logic [7:0]    thresh_i = '0;
    logic          cause_clr_i = 1'b0;
    logic          cause_o, wake_req_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pin_wake_detector uut (
        .clk(clk), .rst(rst), .pins_i(pins_i), .pin_sel_i(pin_sel_i),
        .det_en_i(det_en_i), .mode_i(mode_i), .filt_en_i(filt_en_i),
        .thresh_i(thresh_i), .cause_clr_i(cause_clr_i),
        .cause_o(cause_o), .wake_req_o(wake_req_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic clear_cause();
        cause_clr_i = 1'b1;
        step(1);
        cause_clr_i = 1'b0;
    endtask

    // prepare the channel idle, enabled, with the flag cleared
    task automatic arm(input int sel, input int mode, input bit filt,
                       input int thr, input bit idle);
        det_en_i  = 1'b0;
        pins_i    = idle ? '1 : '0;
        pin_sel_i = 3'(sel);
        mode_i    = 3'(mode);
        thresh_i  = 8'(thr);
        filt_en_i = filt;
        step(6);
        det_en_i = 1'b1;
        step(2);
        clear_cause();
        step(1);
        chk("R9 no event on enable", cause_o, 1'b0);
    endtask

    task automatic run_case(input int sel, input int mode, input bit filt,
                            input int width, input int thr, input bit exp,
                            input string req);
        bit idle;
        idle = (mode == 4);
        arm(sel, mode, filt, thr, idle);
        pins_i[sel] = ~idle;
        step(width);
        pins_i[sel] = idle;
        step(10);
        chk(req, cause_o, exp);
        chk("R8 request follows cause", wake_req_o, cause_o);
        clear_cause();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk("R11 cause after reset", cause_o, 1'b0);
        chk("R11 request after reset", wake_req_o, 1'b0);

        // R1 / R3: every pin, every mode, one 3-cycle pulse, threshold 2
        for (int s = 0; s < NP; s++) begin
            for (int m = 0; m < 8; m++) begin
                run_case(s, m, 1'b0, 3, 2, (m <= 4), "R1 mode sweep");
            end
        end

        // R2 latency without filter, R6 latency with filter
        for (int f = 0; f < 2; f++) begin
            arm(5, 0, f[0], 0, 1'b0);
            pins_i[5] = 1'b1;
            step(f ? 4 : 2);
            chk(f ? "R6 filtered edge not early" : "R2 edge not early", cause_o, 1'b0);
            step(1);
            chk(f ? "R6 filtered edge latency" : "R2 edge latency", cause_o, 1'b1);
            clear_cause();
        end

        // R3: other pins toggle, selected pin stays idle
        arm(3, 2, 1'b0, 0, 1'b0);
        for (int p = 0; p < NP; p++) begin
            if (p != 3) begin
                pins_i[p] = 1'b1;
                step(4);
                pins_i[p] = 1'b0;
                step(4);
            end
        end
        chk("R3 unselected pins ignored", cause_o, 1'b0);

        // R4: pulse width against threshold, both polarities
        for (int m = 3; m <= 4; m++) begin
            for (int w = 1; w <= 6; w++) begin
                for (int t = 0; t <= 6; t += 2) begin
                    run_case(1, m, 1'b0, w, t, (w >= t), "R4 pulse width");
                end
            end
        end

        // R5: saturation at 255
        run_case(6, 3, 1'b0, 300, 255, 1'b1, "R5 long pulse saturates");
        run_case(6, 3, 1'b0, 255, 255, 1'b1, "R5 pulse equals max");
        run_case(6, 3, 1'b0, 254, 255, 1'b0, "R5 pulse below max");

        // R6: glitch rejection and filtered pulse widths
        run_case(2, 2, 1'b1, 1, 0, 1'b0, "R6 glitch dropped");
        run_case(2, 2, 1'b1, 2, 0, 1'b1, "R6 two-cycle level kept");
        run_case(2, 2, 1'b0, 1, 0, 1'b1, "R6 glitch seen unfiltered");
        for (int w = 2; w <= 6; w++) begin
            run_case(0, 3, 1'b1, w, 4, (w >= 4), "R6 filtered pulse width");
        end

        // R7: sticky flag, clear, and detection winning over clear
        arm(4, 2, 1'b0, 0, 1'b0);
        pins_i[4] = 1'b1;
        step(8);
        chk("R7 flag set", cause_o, 1'b1);
        step(20);
        chk("R7 flag sticky", cause_o, 1'b1);
        clear_cause();
        chk("R7 flag cleared", cause_o, 1'b0);
        pins_i[4] = 1'b0;
        step(2);
        cause_clr_i = 1'b1;
        step(1);
        cause_clr_i = 1'b0;
        chk("R7 detection beats clear", cause_o, 1'b1);
        clear_cause();

        // R10: count survives a mode change while enabled
        arm(7, 0, 1'b0, 12, 1'b0);
        pins_i[7] = 1'b1;
        step(10);
        clear_cause();
        mode_i = 3'd3;
        step(4);
        pins_i[7] = 1'b0;
        step(8);
        chk("R10 count kept across mode change", cause_o, 1'b1);
        clear_cause();

        // R9: disabling around the same change drops the count
        arm(7, 0, 1'b0, 12, 1'b0);
        pins_i[7] = 1'b1;
        step(10);
        clear_cause();
        det_en_i = 1'b0;
        step(1);
        mode_i   = 3'd3;
        det_en_i = 1'b1;
        step(3);
        pins_i[7] = 1'b0;
        step(8);
        chk("R9 disable clears count", cause_o, 1'b0);

        // R9: disabled channel ignores edges
        det_en_i = 1'b0;
        mode_i   = 3'd2;
        pins_i[7] = 1'b1;
        step(6);
        pins_i[7] = 1'b0;
        step(6);
        chk("R9 disabled no detection", cause_o, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule